// File: doc/BRIEF.md
# Receive FIFO Pause Flow Control

This block keeps a receive FIFO from overflowing by asking the link partner to stop sending, and honours the partner's own requests to stop. It compares the FIFO fill level, counted in entries, against two watermarks:

- The high mark is one quarter of the FIFO.
- The low mark is one eighth of the FIFO.

Both marks follow the FIFO size, which is 16 KB in gigabit mode and 4 KB at the slower speeds. When the fill level reaches the high mark, the block issues a one-cycle request to the frame builder for a PAUSE frame carrying the largest pause time. Once the FIFO has drained below the low mark, it issues a single request with a zero pause time, which lets the partner resume.

In the other direction, the receive path hands the block a strobe with the pause time decoded from an incoming PAUSE frame. That value loads a countdown timer measured in pause quanta, where one quantum is 512 bit times. The transmit-hold output stays high while this timer is nonzero.

Which features are active depends on three settings: the duplex mode, a symmetric capability enable and an asymmetric capability enable. Building and parsing the frames is handled outside this block.

Top module: `pause_flow_ctrl`

## Requirements
- R1: While `rst_n` is low, `tx_pause_req`, `tx_pause_quanta` and `tx_hold` are all 0.
- R2: Generation is enabled when `full_duplex` and `sym_pause_en` are both 1, and the block is in the flowing state. If a clock edge samples `rx_fill` at or above the high mark, `tx_pause_req` is 1 for the following cycle and `tx_pause_quanta` is 16'hFFFF. In every cycle without a request, `tx_pause_quanta` is 0.
- R3: After a stop request, fill levels at or above the low mark produce no further request. This holds even when the fill level is again at or above the high mark.
- R4: After a stop request, the first edge that samples `rx_fill` below the low mark produces one request with `tx_pause_quanta` equal to 0. The block then returns to the flowing state.
- R5: The watermarks are computed from the FIFO size in entries, which is the byte size divided by `ENTRY_BYTES`. With `gige_mode`=1 the FIFO is 16384 bytes, and with `gige_mode`=0 it is 4096 bytes. The high mark is the entry count divided by 4 and the low mark is the entry count divided by 8.
- R6: No pause request is ever issued when `full_duplex` is 0, or when `sym_pause_en` is 0. This includes the case where only `asym_pause_en` is set.
- R7: Acceptance is enabled when `full_duplex` is 1 and either `sym_pause_en` or `asym_pause_en` is 1. A `rx_pause_valid` strobe with quanta Q then makes `tx_hold` high for exactly Q times the quantum length in clock cycles, starting the cycle after the strobe. The quantum length is `QUANTUM_CYCLES_GIGE` with `gige_mode`=1 and `QUANTUM_CYCLES_SLOW` otherwise.
- R8: A `rx_pause_valid` strobe has no effect on `tx_hold` when acceptance is disabled.
- R9: A new strobe while `tx_hold` is high restarts the count from the new quanta. A strobe with quanta 0 drops `tx_hold` in the next cycle.
- R10: If acceptance becomes disabled, `tx_hold` drops in the next cycle. If generation becomes disabled, the block returns to the flowing state without issuing a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gige_mode | input | 1 | 1 selects the gigabit FIFO size and quantum length |
| full_duplex | input | 1 | Link runs full duplex |
| sym_pause_en | input | 1 | Symmetric pause capability |
| asym_pause_en | input | 1 | Asymmetric pause capability (receive-only pause) |
| rx_fill | input | FILL_W | Receive FIFO occupancy in entries |
| rx_pause_valid | input | 1 | Strobe: a PAUSE frame was decoded |
| rx_pause_quanta | input | QUANTA_W | Pause time of the decoded frame |
| tx_pause_req | output | 1 | One-cycle request to send a PAUSE frame |
| tx_pause_quanta | output | QUANTA_W | Pause time for the requested frame |
| tx_hold | output | 1 | Hold off the transmitter |

## Verification
A received PAUSE strobe and a high-mark crossing can land on the same clock edge. The two paths are independent, so that edge must produce both the stop request and the start of `tx_hold`; neither event may mask or delay the other. The bench provokes this by raising `rx_fill` past the high mark in the same cycle as a strobe with quanta 4. It then checks the request and its 16'hFFFF value in the next cycle, followed by the full 256-cycle hold. Reloading the timer while it is still counting is the second overlap the bench covers, and the behavioural model, compared every clock, judges both.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam int QUANTA_BITS = 16;
  localparam logic [QUANTA_BITS-1:0] PAUSE_MAX = 16'hFFFF;

  typedef enum logic {
    FC_FLOWING = 1'b0,
    FC_PAUSED  = 1'b1
  } fc_state_e;

endpackage

// File: rtl/pfc_mode.sv
module pfc_mode (
  input  logic full_duplex,
  input  logic sym_pause_en,
  input  logic asym_pause_en,
  output logic gen_en,
  output logic acc_en
);

  // Generation needs symmetric capability; acceptance needs either one.
  always_comb begin
    gen_en = full_duplex & sym_pause_en;
    acc_en = full_duplex & (sym_pause_en | asym_pause_en);
  end

endmodule

// File: rtl/pfc_watermark.sv
module pfc_watermark
  import pfc_pkg::*;
#(
  parameter int FILL_W   = 12,
  parameter int QUANTA_W = 16,
  parameter int HIGH_G   = 512,
  parameter int LOW_G    = 256,
  parameter int HIGH_S   = 128,
  parameter int LOW_S    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gige_mode,
  input  logic                gen_en,
  input  logic [FILL_W-1:0]   rx_fill,
  output logic                req,
  output logic [QUANTA_W-1:0] quanta
);

  localparam logic [FILL_W-1:0] HIGH_G_V = FILL_W'(HIGH_G);
  localparam logic [FILL_W-1:0] LOW_G_V  = FILL_W'(LOW_G);
  localparam logic [FILL_W-1:0] HIGH_S_V = FILL_W'(HIGH_S);
  localparam logic [FILL_W-1:0] LOW_S_V  = FILL_W'(LOW_S);

  fc_state_e           st_q, st_d;
  logic                req_q, req_d;
  logic [QUANTA_W-1:0] qa_q, qa_d;
  logic [FILL_W-1:0]   high_mark, low_mark;
  logic                st_en;

  always_comb begin
    high_mark = gige_mode ? HIGH_G_V : HIGH_S_V;
    low_mark  = gige_mode ? LOW_G_V  : LOW_S_V;
  end

  always_comb begin
    st_d  = st_q;
    req_d = 1'b0;
    qa_d  = '0;
    if (!gen_en) begin
      st_d = FC_FLOWING;
    end else begin
      case (st_q)
        FC_FLOWING: begin
          if (rx_fill >= high_mark) begin
            st_d  = FC_PAUSED;
            req_d = 1'b1;
            qa_d  = QUANTA_W'(PAUSE_MAX);
          end
        end
        FC_PAUSED: begin
          if (rx_fill < low_mark) begin
            st_d  = FC_FLOWING;
            req_d = 1'b1;
          end
        end
        default: st_d = FC_FLOWING;
      endcase
    end
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FC_FLOWING;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      qa_q  <= '0;
    end else begin
      req_q <= req_d;
      qa_q  <= qa_d;
    end
  end

  assign req    = req_q;
  assign quanta = qa_q;

endmodule

// File: rtl/pfc_quanta_timer.sv
module pfc_quanta_timer #(
  parameter int QUANTA_W = 16,
  parameter int QCYC_G   = 64,
  parameter int QCYC_S   = 640
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gige_mode,
  input  logic                acc_en,
  input  logic                load,
  input  logic [QUANTA_W-1:0] load_quanta,
  output logic                hold
);

  localparam int QCYC_MAX = (QCYC_G > QCYC_S) ? QCYC_G : QCYC_S;
  localparam int PRE_W    = (QCYC_MAX > 2) ? $clog2(QCYC_MAX) : 1;
  localparam logic [PRE_W-1:0] LIM_G = PRE_W'(QCYC_G - 1);
  localparam logic [PRE_W-1:0] LIM_S = PRE_W'(QCYC_S - 1);

  logic [QUANTA_W-1:0] tmr_q, tmr_d;
  logic [PRE_W-1:0]    pre_q, pre_d;
  logic [PRE_W-1:0]    limit;
  logic                running;
  logic                upd_en;

  always_comb begin
    limit   = gige_mode ? LIM_G : LIM_S;
    running = (tmr_q != '0);
  end

  always_comb begin
    tmr_d = tmr_q;
    pre_d = pre_q;
    if (!acc_en) begin
      tmr_d = '0;
      pre_d = '0;
    end else if (load) begin
      tmr_d = load_quanta;
      pre_d = '0;
    end else if (running) begin
      if (pre_q == limit) begin
        pre_d = '0;
        tmr_d = tmr_q - 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end else begin
      pre_d = '0;
    end
  end

  assign upd_en = load | running | (pre_q != '0) | !acc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      pre_q <= '0;
    end else if (upd_en) begin
      tmr_q <= tmr_d;
      pre_q <= pre_d;
    end
  end

  assign hold = running;

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
  parameter int ENTRY_BYTES         = 8,
  parameter int FIFO_BYTES_GIGE     = 16384,
  parameter int FIFO_BYTES_SLOW     = 4096,
  parameter int QUANTUM_CYCLES_GIGE = 64,
  parameter int QUANTUM_CYCLES_SLOW = 640,
  parameter int QUANTA_W            = 16,
  localparam int ENTRIES_GIGE       = FIFO_BYTES_GIGE / ENTRY_BYTES,
  localparam int ENTRIES_SLOW       = FIFO_BYTES_SLOW / ENTRY_BYTES,
  localparam int ENTRIES_MAX        = (ENTRIES_GIGE > ENTRIES_SLOW) ? ENTRIES_GIGE : ENTRIES_SLOW,
  localparam int FILL_W             = $clog2(ENTRIES_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gige_mode,
  input  logic                full_duplex,
  input  logic                sym_pause_en,
  input  logic                asym_pause_en,
  input  logic [FILL_W-1:0]   rx_fill,
  input  logic                rx_pause_valid,
  input  logic [QUANTA_W-1:0] rx_pause_quanta,
  output logic                tx_pause_req,
  output logic [QUANTA_W-1:0] tx_pause_quanta,
  output logic                tx_hold
);

  localparam int HIGH_G = ENTRIES_GIGE / 4;
  localparam int LOW_G  = ENTRIES_GIGE / 8;
  localparam int HIGH_S = ENTRIES_SLOW / 4;
  localparam int LOW_S  = ENTRIES_SLOW / 8;

  logic gen_en;
  logic acc_en;

  pfc_mode u_mode (
    .full_duplex   (full_duplex),
    .sym_pause_en  (sym_pause_en),
    .asym_pause_en (asym_pause_en),
    .gen_en        (gen_en),
    .acc_en        (acc_en)
  );

  pfc_watermark #(
    .FILL_W   (FILL_W),
    .QUANTA_W (QUANTA_W),
    .HIGH_G   (HIGH_G),
    .LOW_G    (LOW_G),
    .HIGH_S   (HIGH_S),
    .LOW_S    (LOW_S)
  ) u_wm (
    .clk       (clk),
    .rst_n     (rst_n),
    .gige_mode (gige_mode),
    .gen_en    (gen_en),
    .rx_fill   (rx_fill),
    .req       (tx_pause_req),
    .quanta    (tx_pause_quanta)
  );

  pfc_quanta_timer #(
    .QUANTA_W (QUANTA_W),
    .QCYC_G   (QUANTUM_CYCLES_GIGE),
    .QCYC_S   (QUANTUM_CYCLES_SLOW)
  ) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .gige_mode   (gige_mode),
    .acc_en      (acc_en),
    .load        (rx_pause_valid),
    .load_quanta (rx_pause_quanta),
    .hold        (tx_hold)
  );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int ENTRY_BYTES     = 8,
  parameter int FIFO_BYTES_GIGE = 16384,
  parameter int FIFO_BYTES_SLOW = 4096,
  parameter int FILL_W          = 12,
  parameter int QUANTA_W        = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                gige_mode,
  input logic                full_duplex,
  input logic                sym_pause_en,
  input logic                asym_pause_en,
  input logic [FILL_W-1:0]   rx_fill,
  input logic                rx_pause_valid,
  input logic [QUANTA_W-1:0] rx_pause_quanta,
  input logic                tx_pause_req,
  input logic [QUANTA_W-1:0] tx_pause_quanta,
  input logic                tx_hold
);

  localparam logic [FILL_W-1:0] CHK_HI_G = FILL_W'(FIFO_BYTES_GIGE / ENTRY_BYTES / 4);
  localparam logic [FILL_W-1:0] CHK_LO_G = FILL_W'(FIFO_BYTES_GIGE / ENTRY_BYTES / 8);
  localparam logic [FILL_W-1:0] CHK_HI_S = FILL_W'(FIFO_BYTES_SLOW / ENTRY_BYTES / 4);
  localparam logic [FILL_W-1:0] CHK_LO_S = FILL_W'(FIFO_BYTES_SLOW / ENTRY_BYTES / 8);
  localparam logic [QUANTA_W-1:0] CHK_MAX = {QUANTA_W{1'b1}};

  logic gen_ok, acc_ok, stop_req, go_req;
  assign gen_ok   = full_duplex & sym_pause_en;
  assign acc_ok   = full_duplex & (sym_pause_en | asym_pause_en);
  assign stop_req = tx_pause_req & (tx_pause_quanta == CHK_MAX);
  assign go_req   = tx_pause_req & (tx_pause_quanta == '0);

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!tx_pause_req && !tx_hold);
    end
  end

  assert_quanta_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pause_req |-> tx_pause_quanta == '0);

  assert_no_repeat_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);

  assert_stop_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> ($past(gige_mode) ? ($past(rx_fill) >= CHK_HI_G) : ($past(rx_fill) >= CHK_HI_S)));

  assert_resume_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go_req |-> ($past(gige_mode) ? ($past(rx_fill) < CHK_LO_G) : ($past(rx_fill) < CHK_LO_S)));

  assert_no_gen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_ok |=> !tx_pause_req);

  assert_hold_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && rx_pause_valid && rx_pause_quanta != '0) |=> tx_hold);

  assert_zero_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_valid && rx_pause_quanta == '0) |=> !tx_hold);

  assert_hold_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ok |=> !tx_hold);

endmodule

bind pause_flow_ctrl pfc_checker #(
  .ENTRY_BYTES     (ENTRY_BYTES),
  .FIFO_BYTES_GIGE (FIFO_BYTES_GIGE),
  .FIFO_BYTES_SLOW (FIFO_BYTES_SLOW),
  .FILL_W          (FILL_W),
  .QUANTA_W        (QUANTA_W)
) u_chk (.*);

// File: tb/sim_pause_flow_ctrl.sv
`timescale 1ns/1ps
module sim_pause_flow_ctrl;

  localparam int EB = 8;
  localparam int QG = 64;
  localparam int QS = 640;
  localparam int FW = 12;

  logic clk, rst_n;
  logic gige_mode, full_duplex, sym_pause_en, asym_pause_en;
  logic [FW-1:0] rx_fill;
  logic rx_pause_valid;
  logic [15:0] rx_pause_quanta;
  logic tx_pause_req;
  logic [15:0] tx_pause_quanta;
  logic tx_hold;

  pause_flow_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .gige_mode(gige_mode), .full_duplex(full_duplex),
    .sym_pause_en(sym_pause_en), .asym_pause_en(asym_pause_en), .rx_fill(rx_fill),
    .rx_pause_valid(rx_pause_valid), .rx_pause_quanta(rx_pause_quanta),
    .tx_pause_req(tx_pause_req), .tx_pause_quanta(tx_pause_quanta), .tx_hold(tx_hold)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit finished = 0;
  int n_req = 0;
  int last_q = 0;

  // Behavioural reference: flags and a remaining-cycles counter.
  bit m_paused = 0;
  int m_req = 0, m_q = 0, m_left = 0;
  bit cmp_on = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_paused = 0; m_req = 0; m_q = 0; m_left = 0;
    end else begin
      int entries, hi, lo;
      bit gen, acc;
      gen = full_duplex && sym_pause_en;
      acc = full_duplex && (sym_pause_en || asym_pause_en);
      entries = gige_mode ? 16384 / EB : 4096 / EB;
      hi = entries / 4;
      lo = entries / 8;
      m_req = 0; m_q = 0;
      if (!gen) m_paused = 0;
      else if (!m_paused && rx_fill >= hi) begin m_req = 1; m_q = 16'hFFFF; m_paused = 1; end
      else if (m_paused && rx_fill < lo) begin m_req = 1; m_q = 0; m_paused = 0; end
      if (!acc) m_left = 0;
      else if (rx_pause_valid) m_left = rx_pause_quanta * (gige_mode ? QG : QS);
      else if (m_left > 0) m_left = m_left - 1;
    end
    cmp_on = 1;
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk({tag, " req"}, tx_pause_req, m_req);
      chk({tag, " quanta"}, tx_pause_quanta, m_q);
      chk({tag, " hold"}, tx_hold, (m_left > 0) ? 1 : 0);
      if (tx_pause_req) begin n_req++; last_q = tx_pause_quanta; end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pause_rx(int q);
    rx_pause_quanta = 16'(q);
    rx_pause_valid = 1'b1;
    @(negedge clk);
    #1;
    rx_pause_valid = 1'b0;
  endtask

  task automatic count_hold(int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      if (tx_hold) c++;
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 1 expected 0");
    wrap_up();
  end

  initial begin
    int h;
    rst_n = 0; gige_mode = 1; full_duplex = 0; sym_pause_en = 0; asym_pause_en = 0;
    rx_fill = '0; rx_pause_valid = 0; rx_pause_quanta = '0;
    cyc(3);
    chk("R1 req", tx_pause_req, 0);
    chk("R1 hold", tx_hold, 0);
    chk("R1 quanta", tx_pause_quanta, 0);
    rst_n = 1;
    cyc(2);

    // R2: high mark crossing at exactly 512 entries (gigabit)
    tag = "R2"; full_duplex = 1; sym_pause_en = 1; n_req = 0;
    rx_fill = 511; cyc(4);
    chk("R2 below high", n_req, 0);
    rx_fill = 512; cyc(2);
    chk("R2 stop count", n_req, 1);
    chk("R2 stop quanta", last_q, 16'hFFFF);
    // R3: hysteresis
    tag = "R3";
    rx_fill = 700; cyc(4); rx_fill = 400; cyc(6); rx_fill = 256; cyc(4);
    chk("R3 no repeat", n_req, 1);
    // R4: resume below low mark
    tag = "R4";
    rx_fill = 255; cyc(3);
    chk("R4 resume count", n_req, 2);
    chk("R4 resume quanta", last_q, 0);

    // R5: slow FIFO marks 128 / 64
    tag = "R5"; rx_fill = 0; cyc(2); gige_mode = 0; n_req = 0;
    rx_fill = 127; cyc(3); chk("R5 slow below high", n_req, 0);
    rx_fill = 128; cyc(2); chk("R5 slow stop", n_req, 1);
    rx_fill = 64; cyc(3);  chk("R5 slow at low", n_req, 1);
    rx_fill = 63; cyc(2);  chk("R5 slow resume", n_req, 2);
    chk("R5 slow resume quanta", last_q, 0);

    // R6: no generation with asymmetric only or half duplex
    tag = "R6"; gige_mode = 1; sym_pause_en = 0; asym_pause_en = 1; n_req = 0;
    rx_fill = 600; cyc(3); rx_fill = 0; cyc(3);
    sym_pause_en = 1; asym_pause_en = 0; full_duplex = 0;
    rx_fill = 600; cyc(3); rx_fill = 0; cyc(3);
    chk("R6 no requests", n_req, 0);

    // R10: dropping generation clears paused state silently
    tag = "R10"; full_duplex = 1; n_req = 0;
    rx_fill = 600; cyc(2); chk("R10 stop", n_req, 1);
    sym_pause_en = 0; cyc(2); rx_fill = 0; cyc(2);
    chk("R10 silent drop", n_req, 1);
    sym_pause_en = 1; rx_fill = 600; cyc(2);
    chk("R10 fresh stop", n_req, 2);
    chk("R10 fresh stop quanta", last_q, 16'hFFFF);
    rx_fill = 0; cyc(2);

    // R7: hold length
    tag = "R7";
    pause_rx(3); count_hold(250, h); chk("R7 gige hold", h, 3 * QG - 1);
    gige_mode = 0; cyc(1);
    pause_rx(1); count_hold(700, h); chk("R7 slow hold", h, QS - 1);
    gige_mode = 1; sym_pause_en = 0; asym_pause_en = 1; cyc(1);
    pause_rx(2); count_hold(200, h); chk("R7 asym hold", h, 2 * QG - 1);

    // R8: ignored when acceptance disabled
    tag = "R8"; full_duplex = 0; sym_pause_en = 1; cyc(1);
    pause_rx(5); chk("R8 half duplex", tx_hold, 0);
    count_hold(50, h); chk("R8 half duplex hold", h, 0);
    full_duplex = 1; sym_pause_en = 0; asym_pause_en = 0; cyc(1);
    pause_rx(5); count_hold(50, h); chk("R8 no caps hold", h, 0);

    // R9: reload and zero release
    tag = "R9"; sym_pause_en = 1; cyc(1);
    pause_rx(10); count_hold(99, h); chk("R9 first span", h, 99);
    pause_rx(2); count_hold(200, h); chk("R9 reload span", h, 2 * QG - 1);
    pause_rx(40); cyc(10);
    pause_rx(0); chk("R9 zero release", tx_hold, 0);
    count_hold(5, h); chk("R9 stays released", h, 0);

    // R10: dropping acceptance clears hold
    tag = "R10";
    pause_rx(50); cyc(5); chk("R10 hold before drop", tx_hold, 1);
    full_duplex = 0; count_hold(5, h); chk("R10 hold cleared", h, 0);
    full_duplex = 1; cyc(2);

    // R2 with R7 in the same cycle
    tag = "R2"; n_req = 0;
    rx_fill = 600; pause_rx(4);
    chk("R2 coincident req", tx_pause_req, 1);
    chk("R2 coincident quanta", tx_pause_quanta, 16'hFFFF);
    chk("R7 coincident hold", tx_hold, 1);
    count_hold(300, h); chk("R7 coincident span", h, 4 * QG - 1);
    rx_fill = 0; cyc(3);
    chk("R4 final resume", n_req, 2);

    wrap_up();
  end

endmodule